// File: doc/BRIEF.md
# Load Data Aligner and Extender

This block is the load-side datapath stage of a 64-bit RISC core. On each accepted request it adds the sign-extended 16-bit displacement to a base register to form the effective address. It then picks the addressed byte, halfword or word out of an aligned 32-bit memory read word and widens that value to a 64-bit register result, either signed or unsigned.

Two partial-word loads are also supported. The left form and the right form each shift the memory word so that the addressed byte reaches one end of the register word. Each then merges the shifted bytes with the previous destination register value, and the merged word is sign-extended. Misaligned halfword and word accesses are flagged.

The stage is a single registered step with a two-state controller. It starts in `ST_IDLE`. A cycle with `req_valid` high moves it to `ST_DONE`, or keeps it there. A cycle with `req_valid` low returns it to `ST_IDLE`. The results are valid while the controller is in `ST_DONE`.

Top module: `ld_align_ext`

## Requirements
- R1: In 64-bit mode, `eff_addr` equals `base` plus `offset` sign-extended to 64 bits, with wraparound modulo 2^64. In 32-bit mode (`mode64`=0), the low 32 bits of `eff_addr` hold the sum modulo 2^32 and the upper 32 bits are zero.
- R2: Byte ordering is big-endian. Let k be `eff_addr[1:0]`; byte k of the memory word is `rd_word[31-8k -: 8]`. Op 0 (signed byte) sign-extends that byte, and op 1 (unsigned byte) zero-extends it.
- R3: Let h be `eff_addr[1]`; the halfword is `rd_word[31-16h -: 16]`. Op 2 (signed halfword) sign-extends it, and op 3 (unsigned halfword) zero-extends it.
- R4: Op 4 (word) returns `rd_word` sign-extended to 64 bits.
- R5: Op 5 (left partial) places memory bytes k through 3 into register word bytes 0 through 3-k, counted from the MSB. The remaining low bytes come from `rt_old[31:0]`.
- R6: Op 6 (right partial) places memory bytes 0 through k into the low k+1 bytes of the register word, with byte k in the least significant byte. The remaining upper bytes of the word come from `rt_old[31:0]`.
- R7: The 32-bit word produced by op 5 or op 6 is sign-extended from bit 31 to 64 bits.
- R8: When `mode64`=0, `result[63:32]` is zero for every op.
- R9: `addr_err` is 1 for op 2 or 3 when `eff_addr[0]`=1, and for op 4 when `eff_addr[1:0]`≠0; `result` is then zero. Ops 0, 1, 5 and 6 never raise `addr_err`. Op 7 is reserved: its result is zero and `addr_err` is 0.
- R10: Outputs are registered. `rsp_valid` is high in the cycle after a cycle with `req_valid` high and low otherwise. Data outputs hold their values while no request arrives, and all outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| op | input | 3 | Load kind (0..6, 7 reserved) |
| base | input | 64 | Base register value |
| offset | input | 16 | Signed displacement |
| rd_word | input | 32 | Aligned memory read word |
| rt_old | input | 64 | Previous destination register value |
| mode64 | input | 1 | 1 selects 64-bit mode |
| rsp_valid | output | 1 | Result valid (controller in ST_DONE) |
| eff_addr | output | 64 | Effective address |
| result | output | 64 | Register result |
| addr_err | output | 1 | Misaligned access flag |

## Verification
Two things can happen in the same cycle. A new request can be captured while the previous response is still being presented. Address-error detection can also coincide with result forming, because a misaligned halfword or word must suppress the data in the same cycle that it raises the flag. The bench issues requests back to back, mixing misaligned halfword and word accesses with partial-word merges that arrive on the next cycle. A scoreboard compares every response against a model built from the requirements, in strict order. It also checks that error responses carry a zero result, and that the response that follows still shows the merged data and has no stale flag.

// File: rtl/ldal_pkg.sv
package ldal_pkg;
    localparam int XLEN  = 64;
    localparam int WLEN  = 32;
    localparam int OFFW  = 16;
    localparam int BYTES = WLEN / 8;
    localparam int KW    = $clog2(BYTES);

    typedef enum logic [2:0] {
        OP_LB  = 3'd0,
        OP_LBU = 3'd1,
        OP_LH  = 3'd2,
        OP_LHU = 3'd3,
        OP_LW  = 3'd4,
        OP_LWL = 3'd5,
        OP_LWR = 3'd6,
        OP_RSV = 3'd7
    } ld_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } st_e;
endpackage

// File: rtl/ldal_agen.sv
module ldal_agen
    import ldal_pkg::*;
#(
    parameter int AW  = XLEN,
    parameter int OW  = OFFW,
    parameter int NAW = WLEN
) (
    input  logic [AW-1:0] base,
    input  logic [OW-1:0] offset,
    input  logic          mode64,
    output logic [AW-1:0] ea
);
    logic [AW-1:0] sum;

    always_comb begin
        sum = base + {{(AW-OW){offset[OW-1]}}, offset};
        ea  = mode64 ? sum : {{(AW-NAW){1'b0}}, sum[NAW-1:0]};
    end
endmodule

// File: rtl/ldal_extract.sv
module ldal_extract
    import ldal_pkg::*;
#(
    parameter int RW = XLEN,
    parameter int MW = WLEN,
    parameter int SW = KW
) (
    input  logic [MW-1:0] mem,
    input  logic [SW-1:0] k,
    input  ld_op_e        op,
    output logic [RW-1:0] val,
    output logic          misal
);
    logic [7:0]  sel_b;
    logic [15:0] sel_h;

    always_comb begin
        sel_b = mem[(MW-1) - 8*int'(k) -: 8];
        sel_h = mem[(MW-1) - 16*int'(k[SW-1]) -: 16];
        val   = '0;
        misal = 1'b0;
        unique case (op)
            OP_LB:   val = {{(RW-8){sel_b[7]}}, sel_b};
            OP_LBU:  val = {{(RW-8){1'b0}}, sel_b};
            OP_LH: begin
                val   = {{(RW-16){sel_h[15]}}, sel_h};
                misal = k[0];
            end
            OP_LHU: begin
                val   = {{(RW-16){1'b0}}, sel_h};
                misal = k[0];
            end
            OP_LW: begin
                val   = {{(RW-MW){mem[MW-1]}}, mem};
                misal = |k;
            end
            default: val = '0;
        endcase
    end
endmodule

// File: rtl/ldal_merge.sv
module ldal_merge
    import ldal_pkg::*;
#(
    parameter int MW = WLEN,
    parameter int SW = KW
) (
    input  logic [MW-1:0] mem,
    input  logic [SW-1:0] k,
    input  logic [MW-1:0] rt_lo,
    input  logic          left,
    output logic [MW-1:0] word
);
    logic [SW+2:0] sh_l;
    logic [SW+2:0] sh_r;
    logic [MW-1:0] w_left;
    logic [MW-1:0] w_right;

    always_comb begin
        sh_l    = {k, 3'b000};
        sh_r    = {~k, 3'b000};
        w_left  = (mem << sh_l) | (rt_lo & ~({MW{1'b1}} << sh_l));
        w_right = (mem >> sh_r) | (rt_lo & ~({MW{1'b1}} >> sh_r));
        word    = left ? w_left : w_right;
    end
endmodule

// File: rtl/ld_align_ext.sv
module ld_align_ext
    import ldal_pkg::*;
#(
    parameter int RW = XLEN,
    parameter int MW = WLEN,
    parameter int OW = OFFW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    op,
    input  logic [RW-1:0] base,
    input  logic [OW-1:0] offset,
    input  logic [MW-1:0] rd_word,
    input  logic [RW-1:0] rt_old,
    input  logic          mode64,
    output logic          rsp_valid,
    output logic [RW-1:0] eff_addr,
    output logic [RW-1:0] result,
    output logic          addr_err
);
    localparam int SW = $clog2(MW / 8);

    st_e           state, state_nx;
    ld_op_e        op_e;
    logic [RW-1:0] ea_c;
    logic [RW-1:0] ext_val;
    logic          ext_misal;
    logic [MW-1:0] part_word;
    logic [RW-1:0] res_c;

    assign op_e = ld_op_e'(op);

    ldal_agen #(.AW(RW), .OW(OW), .NAW(MW)) u_agen (
        .base(base), .offset(offset), .mode64(mode64), .ea(ea_c)
    );

    ldal_extract #(.RW(RW), .MW(MW), .SW(SW)) u_ext (
        .mem(rd_word), .k(ea_c[SW-1:0]), .op(op_e),
        .val(ext_val), .misal(ext_misal)
    );

    ldal_merge #(.MW(MW), .SW(SW)) u_merge (
        .mem(rd_word), .k(ea_c[SW-1:0]), .rt_lo(rt_old[MW-1:0]),
        .left(op_e == OP_LWL), .word(part_word)
    );

    always_comb begin
        if (op_e == OP_LWL || op_e == OP_LWR)
            res_c = {{(RW-MW){part_word[MW-1]}}, part_word};
        else if (ext_misal)
            res_c = '0;
        else
            res_c = ext_val;
        if (!mode64)
            res_c[RW-1:MW] = '0;
    end

    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = req_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_nx = req_valid ? ST_DONE : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eff_addr <= '0;
            result   <= '0;
            addr_err <= 1'b0;
        end else if (req_valid) begin
            eff_addr <= ea_c;
            result   <= res_c;
            addr_err <= ext_misal;
        end
    end

    assign rsp_valid = (state == ST_DONE);
endmodule

// File: rtl/ld_align_ext_chk.sv
module ld_align_ext_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [2:0]  op,
    input logic [63:0] base,
    input logic [15:0] offset,
    input logic        mode64,
    input logic        rsp_valid,
    input logic [63:0] eff_addr,
    input logic [63:0] result,
    input logic        addr_err
);
    assert_addr_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && mode64 |=> eff_addr == $past(base) + {{48{$past(offset[15])}}, $past(offset)});

    assert_lbu_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && op == 3'd1 |=> result[63:8] == 56'd0);

    assert_lhu_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && op == 3'd3 |=> result[63:16] == 48'd0);

    assert_word_sext_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && mode64 && (op == 3'd4 || op == 3'd5 || op == 3'd6)
        |=> result[63:32] == {32{result[31]}});

    assert_narrow_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !mode64 |=> result[63:32] == 32'd0 && eff_addr[63:32] == 32'd0);

    assert_no_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (op == 3'd0 || op == 3'd1 || op >= 3'd5) |=> !addr_err);

    assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && addr_err |-> result == 64'd0);

    assert_rsp_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_rsp_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && $stable(result) && $stable(eff_addr));
endmodule

bind ld_align_ext ld_align_ext_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op),
    .base(base), .offset(offset), .mode64(mode64),
    .rsp_valid(rsp_valid), .eff_addr(eff_addr), .result(result),
    .addr_err(addr_err)
);

// File: tb/tb_ld_align_ext.sv
module tb_ld_align_ext;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [63:0] base = '0;
    logic [15:0] offset = '0;
    logic [31:0] rd_word = '0;
    logic [63:0] rt_old = '0;
    logic        mode64 = 1'b1;
    logic        rsp_valid;
    logic [63:0] eff_addr;
    logic [63:0] result;
    logic        addr_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [63:0] ea;
        logic [63:0] res;
        logic        err;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    ld_align_ext dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op),
        .base(base), .offset(offset), .rd_word(rd_word), .rt_old(rt_old),
        .mode64(mode64), .rsp_valid(rsp_valid), .eff_addr(eff_addr),
        .result(result), .addr_err(addr_err)
    );

    function automatic exp_t model(input logic [2:0] o, input logic [63:0] b,
                                   input logic [15:0] f, input logic [31:0] m,
                                   input logic [63:0] r, input logic m64);
        exp_t e;
        logic [63:0] a;
        logic [31:0] w;
        logic [7:0]  by;
        logic [15:0] hw;
        int k;
        a = b + {{48{f[15]}}, f};
        if (!m64) a = {32'd0, a[31:0]};
        k = int'(a[1:0]);
        by = m[31-8*k -: 8];
        hw = m[31-16*int'(a[1]) -: 16];
        e.err = 1'b0;
        e.res = '0;
        case (o)
            3'd0: e.res = {{56{by[7]}}, by};
            3'd1: e.res = {56'd0, by};
            3'd2: begin e.err = a[0]; e.res = {{48{hw[15]}}, hw}; end
            3'd3: begin e.err = a[0]; e.res = {48'd0, hw}; end
            3'd4: begin e.err = (k != 0); e.res = {{32{m[31]}}, m}; end
            3'd5: begin
                w = r[31:0];
                for (int i = 0; i <= 3 - k; i++) w[31-8*i -: 8] = m[31-8*(k+i) -: 8];
                e.res = {{32{w[31]}}, w};
            end
            3'd6: begin
                w = r[31:0];
                for (int i = 0; i <= k; i++) w[31-8*(3-k+i) -: 8] = m[31-8*i -: 8];
                e.res = {{32{w[31]}}, w};
            end
            default: e.res = '0;
        endcase
        if (e.err) e.res = '0;
        if (!m64) e.res[63:32] = '0;
        e.ea = a;
        return e;
    endfunction

    task automatic drive(input logic [2:0] o, input logic [63:0] b, input logic [15:0] f,
                         input logic [31:0] m, input logic [63:0] r, input logic m64,
                         input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; op = o; base = b; offset = f;
        rd_word = m; rt_old = r; mode64 = m64;
        e = model(o, b, f, m, r, m64);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // scoreboard monitor: compares each response in order
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R10", "unexpected response", 64'd1, 64'd0);
                end else begin
                    e = sb.pop_front();
                    check(eff_addr == e.ea && result == e.res && addr_err == e.err,
                          e.tag, "ea/result/err",
                          result ^ {63'd0, addr_err} ^ eff_addr,
                          e.res ^ {63'd0, e.err} ^ e.ea);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rsp_valid == 0 && result == 0 && eff_addr == 0 && addr_err == 0,
              "R10", "reset state", result, 64'd0);
        rst_n = 1'b1;
        // R1 address forming with negative and positive offsets
        drive(3'd4, 64'h0000_0000_0000_1000, 16'hFFFC, 32'h1234_5678, 64'd0, 1'b1, "R1");
        drive(3'd4, 64'hFFFF_FFFF_FFFF_FFF8, 16'h0010, 32'h8000_0001, 64'd0, 1'b1, "R1");
        // R2 bytes at each offset, signed and unsigned
        for (int k = 0; k < 4; k++) begin
            drive(3'd0, 64'h100 + 64'(k), 16'd0, 32'h80_7F_C3_11, 64'd0, 1'b1, "R2");
            drive(3'd1, 64'h100 + 64'(k), 16'd0, 32'h80_7F_C3_11, 64'd0, 1'b1, "R2");
        end
        // R3 halfwords
        drive(3'd2, 64'h200, 16'd0, 32'h8001_7FFE, 64'd0, 1'b1, "R3");
        drive(3'd2, 64'h202, 16'd0, 32'h8001_F00E, 64'd0, 1'b1, "R3");
        drive(3'd3, 64'h200, 16'd0, 32'h8001_7FFE, 64'd0, 1'b1, "R3");
        drive(3'd3, 64'h1FF, 16'd3, 32'h8001_F00E, 64'd0, 1'b1, "R3");
        // R4 word
        drive(3'd4, 64'h300, 16'd0, 32'hDEAD_BEEF, 64'd0, 1'b1, "R4");
        idle(2);
        // R5 R6 R7 partial loads each offset, back to back with errors mixed in
        for (int k = 0; k < 4; k++) begin
            drive(3'd5, 64'h400 + 64'(k), 16'd0, 32'h8899_AABB, 64'h1111_2222_3344_5566, 1'b1, "R5");
            drive(3'd2, 64'h401, 16'd0, 32'hFFFF_FFFF, 64'd0, 1'b1, "R9");
            drive(3'd6, 64'h400 + 64'(k), 16'd0, 32'h0899_AABB, 64'hFFFF_0000_C344_5566, 1'b1, "R6");
            drive(3'd4, 64'h402, 16'd0, 32'hFFFF_FFFF, 64'd0, 1'b1, "R9");
        end
        drive(3'd5, 64'h500, 16'd0, 32'hF000_0000, 64'd0, 1'b1, "R7");
        drive(3'd6, 64'h503, 16'd0, 32'h7000_0000, 64'hFFFF_FFFF_8000_0000, 1'b1, "R7");
        // R8 narrow mode with wrap of low 32 bits
        drive(3'd4, 64'hABCD_0000_FFFF_FFFC, 16'h0008, 32'h8765_4321, 64'd0, 1'b0, "R8");
        drive(3'd0, 64'h1234_5678_0000_0010, 16'hFFFF, 32'h0000_00FF, 64'd0, 1'b0, "R8");
        drive(3'd5, 64'h10, 16'd1, 32'h8899_AABB, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R8");
        // R9 reserved op and error cases
        drive(3'd7, 64'h600, 16'd0, 32'hFFFF_FFFF, 64'hFFFF, 1'b1, "R9");
        drive(3'd3, 64'h603, 16'd0, 32'hFFFF_FFFF, 64'd0, 1'b1, "R9");
        drive(3'd4, 64'h601, 16'd0, 32'hFFFF_FFFF, 64'd0, 1'b1, "R9");
        drive(3'd0, 64'h603, 16'd0, 32'hFFFF_FF80, 64'd0, 1'b1, "R9");
        idle(3);
        // R10 outputs hold while idle
        check(rsp_valid == 0 && result == 64'hFFFF_FFFF_FFFF_FF80,
              "R10", "hold when idle", result, 64'hFFFF_FFFF_FFFF_FF80);
        check(sb.size() == 0, "R10", "all responses seen", 64'(sb.size()), 64'd0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule